// File: doc/BRIEF.md
# Wrapping Burst Address Generator

This block turns a single burst request into the stream of per-beat addresses a bus manager puts out. A one-cycle start strobe captures a start address, a beat-count code (4, 8 or 16 beats), a beat-size code (1, 2 or 4 bytes) and a mode bit. The mode bit selects wrapping or linear incrementing. From the next cycle on, the generator presents one address per beat and moves to the following address only when the downstream side accepts the beat with ready. It flags the final beat and then falls back to idle.

In wrapping mode the addresses never leave the naturally aligned block whose byte size is the beat count times the beat size. The generator holds every address bit above log2 of that size. It steps only the bits below it, modulo the block size, so the sequence climbs to the top of the block and restarts at its base. A cache-line fill that begins mid-line fetches exactly that one line. In incrementing mode the address simply grows by the beat size on every beat.

A start whose address is not a multiple of the beat size is refused, as is a start with a reserved code. A refused start produces a one-cycle error pulse and no burst. The generator does not drive bus handshakes, data or responses. It also does not split a burst that crosses a boundary.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, busy_o, last_o and err_o are all low.
- R2: beats_i code 0/1/2 selects 4/8/16 beats and size_i code 0/1/2 selects 1/2/4 bytes per beat. An accepted start makes busy_o high in the next cycle, with addr_o equal to the start address.
- R3: With wrap_i high at start, each accepted beat advances the address by the beat size modulo B = beats × bytes. All address bits at and above log2(B) keep the start address value, so the sequence returns to the block base instead of reaching base + B.
- R4: With wrap_i low at start, each accepted beat raises the address by exactly the beat size, with no wrap.
- R5: The address advances only in a cycle where busy_o and ready_i are both high. While ready_i is low, addr_o and busy_o hold.
- R6: last_o is high exactly on the final beat of a burst. busy_o is low in the cycle after that beat is accepted.
- R7: A start whose address is not a multiple of the beat size starts no burst, and err_o is high for exactly the one following cycle.
- R8: A start with beats_i = 3 or size_i = 3 is refused the same way, with a one-cycle err_o pulse and no burst.
- R9: A start strobe while busy_o is high is ignored and leaves the running sequence unchanged.
- R10: A burst presents exactly as many accepted beats as its beat count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst request strobe, sampled while idle |
| addr_i | input | ADDR_W | Burst start address |
| beats_i | input | 2 | Beat-count code: 0=4, 1=8, 2=16, 3 reserved |
| size_i | input | 2 | Beat-size code: 0=1 byte, 1=2 bytes, 2=4 bytes, 3 reserved |
| wrap_i | input | 1 | 1 = wrapping burst, 0 = incrementing burst |
| ready_i | input | 1 | Downstream accepts the current beat |
| busy_o | output | 1 | A beat address is being presented |
| addr_o | output | ADDR_W | Current beat address |
| last_o | output | 1 | Current beat is the final one of the burst |
| err_o | output | 1 | One-cycle pulse for a refused start |

## Verification
The hardest case to reach from the ports is a wrap taken while the downstream side is stalling. The wrap point, the last beat and a ready-low cycle must line up inside one block. That block must be sized by every beat-count and beat-size pair. The stimulus covers each pair, both modes and every aligned start offset within the block. It drives ready from a pattern seeded per burst, so stalls fall on different beats relative to the wrap. Some bursts also receive a second start strobe with a different address mid-burst, which must leave the sequence untouched.

// File: rtl/bag_pkg.sv
package bag_pkg;
    typedef enum logic [1:0] {
        BC_4   = 2'd0,
        BC_8   = 2'd1,
        BC_16  = 2'd2,
        BC_RSV = 2'd3
    } beat_cnt_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSV  = 2'd3
    } beat_size_e;

    // log2 of the smallest beat count (4)
    localparam int MIN_BEATS_LG = 2;
    // beat counter wide enough for the largest count (16)
    localparam int CNT_W = MIN_BEATS_LG + 2;
endpackage

// File: rtl/bag_geom.sv
// Decodes the request codes into block mask, step and beat index.
module bag_geom
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        beats_i,
    input  logic [1:0]        size_i,
    output logic              legal_o,
    output logic [ADDR_W-1:0] mask_o,
    output logic [ADDR_W-1:0] step_o,
    output logic [CNT_W-1:0]  last_idx_o
);
    beat_cnt_e  bc;
    beat_size_e sz;
    int unsigned blk_lg;

    always_comb begin
        bc         = beat_cnt_e'(beats_i);
        sz         = beat_size_e'(size_i);
        legal_o    = (bc != BC_RSV) && (sz != SZ_RSV);
        blk_lg     = MIN_BEATS_LG + 32'(beats_i) + 32'(size_i);
        mask_o     = (ADDR_W'(1) << blk_lg) - ADDR_W'(1);
        step_o     = ADDR_W'(1) << size_i;
        last_idx_o = CNT_W'((32'd1 << (MIN_BEATS_LG + 32'(beats_i))) - 32'd1);
    end
endmodule

// File: rtl/bag_step.sv
// Next beat address: bits inside the block mask take the sum, bits above hold in wrap mode.
module bag_step #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_i,
    input  logic [ADDR_W-1:0] step_i,
    input  logic [ADDR_W-1:0] mask_i,
    input  logic              wrap_i,
    output logic [ADDR_W-1:0] nxt_o
);
    logic [ADDR_W-1:0] sum;

    assign sum = cur_i + step_i;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign nxt_o[i] = (wrap_i && !mask_i[i]) ? cur_i[i] : sum[i];
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        beats_i,
    input  logic [1:0]        size_i,
    input  logic              wrap_i,
    input  logic              ready_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o,
    output logic              err_o
);
    typedef struct packed {
        logic              busy;
        logic              wrap;
        logic              err;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] step;
    } st_t;

    st_t st_d, st_q;

    logic              req_legal;
    logic [ADDR_W-1:0] req_mask;
    logic [ADDR_W-1:0] req_step;
    logic [CNT_W-1:0]  req_last_idx;
    logic              req_misal;
    logic [ADDR_W-1:0] nxt_addr;

    // signals seen by the bound checker
    logic              wrap_q;
    logic [ADDR_W-1:0] mask_q;

    bag_geom #(.ADDR_W(ADDR_W)) u_geom (
        .beats_i    (beats_i),
        .size_i     (size_i),
        .legal_o    (req_legal),
        .mask_o     (req_mask),
        .step_o     (req_step),
        .last_idx_o (req_last_idx)
    );

    bag_step #(.ADDR_W(ADDR_W)) u_step (
        .cur_i  (st_q.addr),
        .step_i (st_q.step),
        .mask_i (st_q.mask),
        .wrap_i (st_q.wrap),
        .nxt_o  (nxt_addr)
    );

    assign req_misal = |(addr_i & (req_step - ADDR_W'(1)));

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                if (!req_legal || req_misal) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                    st_d.wrap = wrap_i;
                    st_d.cnt  = req_last_idx;
                    st_d.addr = addr_i;
                    st_d.mask = req_mask;
                    st_d.step = req_step;
                end
            end
        end else if (ready_i) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.addr = nxt_addr;
                st_d.cnt  = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign addr_o = st_q.addr;
    assign last_o = st_q.busy && (st_q.cnt == '0);
    assign err_o  = st_q.err;
    assign wrap_q = st_q.wrap;
    assign mask_q = st_q.mask;
endmodule

// File: rtl/bag_chk.sv
module bag_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready_i,
    input logic              busy_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              last_o,
    input logic              err_o,
    input logic              wrap_q,
    input logic [ADDR_W-1:0] mask_q
);
    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !ready_i |=> busy_o && $stable(addr_o));

    // R6
    idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && ready_i && last_o |=> !busy_o);

    // R10
    keep_going_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && ready_i && !last_o |=> busy_o);

    // R3
    wrap_confine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && ready_i && !last_o && wrap_q |=>
        ((addr_o & ~mask_q) == ($past(addr_o) & ~mask_q)));

    // R7
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o);
endmodule

bind burst_addr_gen bag_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_i (ready_i),
    .busy_o  (busy_o),
    .addr_o  (addr_o),
    .last_o  (last_o),
    .err_o   (err_o),
    .wrap_q  (wrap_q),
    .mask_q  (mask_q)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [1:0]  beats_i = '0;
    logic [1:0]  size_i = '0;
    logic        wrap_i = 1'b0;
    logic        ready_i = 1'b0;
    logic        busy_o;
    logic [31:0] addr_o;
    logic        last_o;
    logic        err_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [31:0] a;
        logic        l;
        bit          wr;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .beats_i(beats_i), .size_i(size_i), .wrap_i(wrap_i), .ready_i(ready_i),
        .busy_o(busy_o), .addr_o(addr_o), .last_o(last_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops one expected beat per accepted beat, checks stall hold
    logic        p_busy = 1'b0;
    logic        p_ready = 1'b0;
    logic [31:0] p_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_busy && !p_ready && busy_o)
                chk(addr_o == p_addr, "R5 stall hold", addr_o, p_addr);
            if (busy_o && ready_i) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R10 extra beat", addr_o, 32'h0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(addr_o == e.a, e.wr ? "R2/R3 wrap addr" : "R2/R4 incr addr", addr_o, e.a);
                    chk(last_o == e.l, "R6 last flag", {31'b0, last_o}, {31'b0, e.l});
                end
            end
        end
        p_busy  = busy_o;
        p_ready = ready_i;
        p_addr  = addr_o;
    end

    task automatic run_burst(input logic [31:0] a, input int bc, input int sz,
                             input bit wr, input int seed, input bit poke);
        int nb, by, blk, cyc;
        logic [31:0] base;
        nb   = 4 << bc;
        by   = 1 << sz;
        blk  = nb * by;
        base = a - (a % blk);
        for (int k = 0; k < nb; k++) begin
            exp_t e;
            e.a  = wr ? base + ((a - base + k * by) % blk) : a + k * by;
            e.l  = (k == nb - 1);
            e.wr = wr;
            q.push_back(e);
        end
        @(posedge clk); #1;
        start_i = 1'b1; addr_i = a; beats_i = 2'(bc); size_i = 2'(sz); wrap_i = wr;
        @(posedge clk); #1;
        start_i = 1'b0;
        cyc = 0;
        while (q.size() != 0 && cyc < 400) begin
            ready_i = ((cyc * 5 + seed) % 4) != 0;
            if (poke && cyc == 2) begin
                start_i = 1'b1; addr_i = a ^ 32'h0000_0040; wrap_i = ~wr; // R9
            end else begin
                start_i = 1'b0;
            end
            @(posedge clk); #1;
            cyc++;
        end
        start_i = 1'b0;
        ready_i = 1'b0;
        chk(q.size() == 0, "R10 beats missing", 32'(q.size()), 32'h0);
        chk(!busy_o, "R6 idle after last", {31'b0, busy_o}, 32'h0);
        q.delete();
    endtask

    task automatic bad_start(input logic [31:0] a, input int bc, input int sz, input string req);
        @(posedge clk); #1;
        start_i = 1'b1; addr_i = a; beats_i = 2'(bc); size_i = 2'(sz); wrap_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        chk(err_o == 1'b1, req, {31'b0, err_o}, 32'h1);
        chk(busy_o == 1'b0, req, {31'b0, busy_o}, 32'h0);
        @(posedge clk); #1;
        chk(err_o == 1'b0, req, {31'b0, err_o}, 32'h0);
        chk(busy_o == 1'b0, req, {31'b0, busy_o}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seed;
        repeat (3) @(posedge clk);
        #1;
        // R1
        chk(!busy_o && !last_o && !err_o, "R1 reset state", {29'b0, busy_o, last_o, err_o}, 32'h0);
        rst_n = 1'b1;

        // R3: 8-beat word wrap from 0x2008 must go 2008..201C,2000,2004
        run_burst(32'h0000_2008, 1, 2, 1'b1, 1, 1'b0);

        seed = 0;
        for (int sz = 0; sz < 3; sz++)
            for (int bc = 0; bc < 3; bc++)
                for (int wr = 0; wr < 2; wr++)
                    for (int k = 0; k < (4 << bc); k++) begin
                        logic [31:0] hi;
                        hi = 32'h0000_2000 + 32'((sz * 3 + bc) * 32'h100) + (wr != 0 ? 32'h8000_0000 : 32'h0);
                        seed++;
                        run_burst(hi + 32'(k * (1 << sz)), bc, sz, wr != 0, seed, (seed % 5) == 0);
                    end

        // R4 incr across a block boundary keeps counting upward
        run_burst(32'h0000_03F8, 2, 2, 1'b0, 3, 1'b1);

        // R7 misaligned starts
        bad_start(32'h0000_2001, 0, 1, "R7 misaligned half");
        bad_start(32'h0000_2002, 1, 2, "R7 misaligned word");
        // R8 reserved codes
        bad_start(32'h0000_2000, 3, 2, "R8 reserved beats");
        bad_start(32'h0000_2000, 0, 3, "R8 reserved size");

        // recovers after errors
        run_burst(32'h0000_3004, 0, 2, 1'b1, 2, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule